// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This controller merges a group of interrupt input lines into one active-high request for a processor. Each input has an enable bit, a three-bit priority and a choice between level and edge sensing. Each input also has its own stored handler address. Inputs pass through a two-stage synchronizer. Edge-sensed inputs latch a pending flag on a rising edge. Level-sensed inputs count as pending while they stay high.

The processor reaches the controller through a small register bus with read and write strobes, a 6-bit word address and registered read data. When the processor reads the vector register, the winning source is committed: its handler address comes back, its priority becomes the level in service, and any level already in service is pushed onto an eight-entry last-in first-out stack. A write to the end-of-service register pops that stack, so an interrupted lower-priority handler resumes. If the stack is empty, the same write returns the controller to idle. The request line is raised only for an enabled pending source whose priority is strictly above the level in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Among enabled pending sources, the one with the numerically highest priority wins; 7 is the highest level and 0 the lowest.
- R2: When the best priority is shared by several sources, the lowest-numbered of them wins.
- R3: A read of the vector register (address 0x20) returns, on busRdata one cycle later, the handler address of the source that wins at the read. If a more urgent source arrives before the read, the read returns that source's handler.
- R4: A vector read that selects a source drops irq unless a still higher source is pending. It clears the pending flag of an edge-sensed source. A level-sensed source stays pending while its input is high.
- R5: While a level is in service, a newly pending source with a higher priority raises irq. The next vector read pushes the old level and takes the new source's priority as the level in service.
- R6: irq is high only when some enabled pending source has a priority strictly above the level in service. When idle, any enabled pending source raises it.
- R7: A write to the end-of-service register (address 0x21) restores the level from the top of the stack. If the stack is empty, the write returns the controller to idle.
- R8: The stack holds 8 entries. A push while it is full is dropped, and the depth never exceeds 8.
- R9: A vector read with no enabled pending source returns the default vector register (address 0x22, reset 0). It leaves the level, the stack and the idle or busy state unchanged.
- R10: A source whose enable bit is 0 never raises irq and never wins a vector read.
- R11: An edge-sensed source becomes pending on a rising edge of its input, and stays pending after the input falls until a vector read selects it.
- R12: Source n is configured at word address n: bits [2:0] hold the priority, bit 3 selects edge sensing (1) or level sensing (0), and bit 4 is the enable. Its handler address is at 0x10+n. All of these read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIn | input | NUM_SRC | Asynchronous interrupt source lines |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 6 | Word address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid the cycle after busRd |
| irq | output | 1 | Interrupt request to the processor |

## Verification
On every cycle the assertions check the request rule against the level in service, the commit of a new level on a vector read, the push and pop of the stack depth, the depth bound, the return to idle, and the fact that a read with nothing pending leaves the state alone. Only the bench's scenarios can show which handler address each mix of priorities and ties returns. The same holds for the difference in persistence between edge and level sources, for enable masking as seen at the ports, and for the correct unwinding of a nested sequence, including a full stack, back through end-of-service writes.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] HDL_BASE  = 6'h10;
  localparam logic [ADDR_W-1:0] VEC_ADDR  = 6'h20;
  localparam logic [ADDR_W-1:0] EOI_ADDR  = 6'h21;
  localparam logic [ADDR_W-1:0] DFLT_ADDR = 6'h22;

  typedef enum logic [1:0] {RD_CFG, RD_HDL, RD_VEC, RD_DFLT} rdSel_e;

  typedef struct packed {
    logic       cfgWr;
    logic       hdlWr;
    logic       dfltWr;
    logic       vecRd;
    logic       eoiWr;
    logic       rdEn;
    rdSel_e     rdSel;
    logic [3:0] idx;
  } strobe_t;
endpackage

// File: rtl/pic_control.sv
module pic_control
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobe
);
  localparam logic [4:0] NSRC = 5'(NUM_SRC);

  logic inRange;
  assign inRange = ({1'b0, busAddr[3:0]} < NSRC);

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_CFG;
    strobe.idx   = busAddr[3:0];
    if (busAddr[5:4] == 2'b00 && inRange) begin
      strobe.cfgWr = busWr;
      strobe.rdEn  = busRd;
      strobe.rdSel = RD_CFG;
    end else if (busAddr[5:4] == HDL_BASE[5:4] && inRange) begin
      strobe.hdlWr = busWr;
      strobe.rdEn  = busRd;
      strobe.rdSel = RD_HDL;
    end else if (busAddr == VEC_ADDR) begin
      strobe.vecRd = busRd;
      strobe.rdEn  = busRd;
      strobe.rdSel = RD_VEC;
    end else if (busAddr == EOI_ADDR) begin
      strobe.eoiWr = busWr;
    end else if (busAddr == DFLT_ADDR) begin
      strobe.dfltWr = busWr;
      strobe.rdEn   = busRd;
      strobe.rdSel  = RD_DFLT;
    end
  end
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_SRC-1:0]                srcIn,
  input  logic [DATA_W-1:0]                 wdata,
  input  strobe_t                           strobe,
  output logic [DATA_W-1:0]                 rdata,
  output logic                              irq,
  output logic                              active,
  output logic [PRIO_W-1:0]                 curLvl,
  output logic [$clog2((1<<PRIO_W)+1)-1:0]  depth,
  output logic                              winValid,
  output logic [PRIO_W-1:0]                 winPrio
);
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int LEVELS  = 1 << PRIO_W;
  localparam int DEPTH_W = $clog2(LEVELS + 1);
  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(LEVELS);

  logic [PRIO_W-1:0] prio     [NUM_SRC];
  logic [DATA_W-1:0] handler  [NUM_SRC];
  logic [NUM_SRC-1:0] edgeMode, enable;
  logic [DATA_W-1:0] dfltVec;
  logic [NUM_SRC-1:0] sync1, sync2, syncPrev, edgePend, req;
  logic [IDX_W-1:0]  winIdx, selIdx;
  logic [PRIO_W-1:0] stack [LEVELS];
  logic              commit, doPush;
  logic [PRIO_W-1:0] topIdx;

  assign selIdx = strobe.idx[IDX_W-1:0];
  assign commit = strobe.vecRd && winValid;
  assign doPush = commit && active && (depth < FULL);
  assign topIdx = PRIO_W'(depth - 1'b1);

  // configuration registers, one set per source
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prio[i]     <= '0;
          edgeMode[i] <= 1'b0;
          enable[i]   <= 1'b0;
          handler[i]  <= '0;
          edgePend[i] <= 1'b0;
        end else begin
          if (strobe.cfgWr && selIdx == IDX_W'(i)) begin
            prio[i]     <= wdata[PRIO_W-1:0];
            edgeMode[i] <= wdata[PRIO_W];
            enable[i]   <= wdata[PRIO_W+1];
          end
          if (strobe.hdlWr && selIdx == IDX_W'(i))
            handler[i] <= wdata;
          edgePend[i] <= (edgePend[i] && !(commit && winIdx == IDX_W'(i)))
                       || (edgeMode[i] && sync2[i] && !syncPrev[i]);
        end
      end
      assign req[i] = enable[i] && (edgeMode[i] ? edgePend[i] : sync2[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1    <= '0;
      sync2    <= '0;
      syncPrev <= '0;
      dfltVec  <= '0;
    end else begin
      sync1    <= srcIn;
      sync2    <= sync1;
      syncPrev <= sync2;
      if (strobe.dfltWr) dfltVec <= wdata;
    end
  end

  // arbitration: strict greater keeps the lower index on ties
  always_comb begin
    winValid = 1'b0;
    winPrio  = '0;
    winIdx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (!winValid || prio[i] > winPrio)) begin
        winValid = 1'b1;
        winPrio  = prio[i];
        winIdx   = IDX_W'(i);
      end
    end
  end

  assign irq = winValid && (!active || winPrio > curLvl);

  // level in service and nesting stack
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      curLvl <= '0;
      depth  <= '0;
    end else if (commit) begin
      active <= 1'b1;
      curLvl <= winPrio;
      if (doPush) depth <= depth + 1'b1;
    end else if (strobe.eoiWr) begin
      if (depth != '0) begin
        curLvl <= stack[topIdx];
        depth  <= depth - 1'b1;
      end else begin
        active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) stack[depth[PRIO_W-1:0]] <= curLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (strobe.rdEn) begin
      unique case (strobe.rdSel)
        RD_CFG:  rdata <= DATA_W'({enable[selIdx], edgeMode[selIdx], prio[selIdx]});
        RD_HDL:  rdata <= handler[selIdx];
        RD_VEC:  rdata <= winValid ? handler[winIdx] : dfltVec;
        default: rdata <= dfltVec;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [5:0]         busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irq
);
  localparam int DEPTH_W = $clog2((1 << PRIO_W) + 1);

  strobe_t             strobe;
  logic                active, winValid;
  logic [PRIO_W-1:0]   curLvl, winPrio;
  logic [DEPTH_W-1:0]  depth;

  pic_control #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .strobe(strobe)
  );

  pic_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wdata(busWdata), .strobe(strobe),
    .rdata(busRdata), .irq(irq), .active(active), .curLvl(curLvl),
    .depth(depth), .winValid(winValid), .winPrio(winPrio)
  );
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int PRIO_W = 3
) (
  input logic                                clk,
  input logic                                rstN,
  input logic                                busRd,
  input logic                                busWr,
  input logic [5:0]                          busAddr,
  input logic                                irq,
  input logic                                active,
  input logic [PRIO_W-1:0]                   curLvl,
  input logic [$clog2((1<<PRIO_W)+1)-1:0]    depth,
  input logic                                winValid,
  input logic [PRIO_W-1:0]                   winPrio
);
  localparam int DEPTH_W = $clog2((1 << PRIO_W) + 1);
  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(1 << PRIO_W);

  logic vecRd, eoiWr;
  assign vecRd = busRd && busAddr == 6'h20;
  assign eoiWr = busWr && busAddr == 6'h21;

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    depth <= FULL);
  p_irq_needs_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> winValid);
  p_irq_strict_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irq && active) |-> (winPrio > curLvl));
  p_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (vecRd && winValid) |=> (active && curLvl == $past(winPrio)));
  p_push_r5: assert property (@(posedge clk) disable iff (!rstN)
    (vecRd && winValid && active && depth < FULL) |=> depth == DEPTH_W'($past(depth) + 1'b1));
  p_pop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (eoiWr && depth != '0) |=> depth == DEPTH_W'($past(depth) - 1'b1));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (eoiWr && depth == '0) |=> !active);
  p_empty_rd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (vecRd && !winValid) |=> ($stable(depth) && $stable(curLvl) && $stable(active)));
endmodule

bind prio_irq_ctrl pic_checker #(.PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
  .irq(irq), .active(active), .curLvl(curLvl), .depth(depth),
  .winValid(winValid), .winPrio(winPrio)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int NSRC = 8;
  localparam logic [5:0] A_VEC = 6'h20, A_EOI = 6'h21, A_DFLT = 6'h22;
  localparam logic [31:0] DFLT = 32'hDEAD_0000;
  // source priorities used by the table: 0:3 1:5 2:5 3:1 4:7 5:0 6:3 7:7
  localparam logic [2:0] PR [NSRC] = '{3'd3, 3'd5, 3'd5, 3'd1, 3'd7, 3'd0, 3'd3, 3'd7};
  // {lines, expected winner}; winner 8 means the default vector
  localparam logic [11:0] VTAB [9] = '{
    {8'h01, 4'd0}, {8'h06, 4'd1}, {8'h90, 4'd4}, {8'h28, 4'd3}, {8'h41, 4'd0},
    {8'hFF, 4'd4}, {8'h00, 4'd8}, {8'h80, 4'd7}, {8'h24, 4'd2}};

  logic clk = 1'b0, rstN = 1'b0;
  logic [NSRC-1:0] srcIn = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic irq;
  int nChecks = 0, nErr = 0;
  logic [31:0] d;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (.clk(clk), .rstN(rstN), .srcIn(srcIn), .busWr(busWr),
    .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq));

  function automatic logic [31:0] hdl(input int i);
    return 32'h1000 + 32'(i) * 32'h10;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk); busAddr = a; busWdata = v; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0; v = busRdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6 reset irq", 32'(irq), 0);
    rd(6'h00, d); chk("R12 reset cfg", d, 0);
    rd(A_VEC, d); chk("R9 reset default", d, 0);

    for (int i = 0; i < NSRC; i++) begin
      wr(6'(i), 32'h10 | 32'(PR[i]));
      wr(6'h10 + 6'(i), hdl(i));
    end
    wr(A_DFLT, DFLT);

    // arbitration table (R1, R2, R3)
    for (int k = 0; k < 9; k++) begin
      srcIn = VTAB[k][11:4];
      settle();
      chk("R6 table irq", 32'(irq), 32'(VTAB[k][11:4] != 0));
      rd(A_VEC, d);
      chk("R1 R2 R3 table vector", d, (VTAB[k][3:0] == 4'd8) ? DFLT : hdl(int'(VTAB[k][3:0])));
      chk("R4 irq after read", 32'(irq), 0);
      srcIn = '0;
      settle();
      if (VTAB[k][3:0] != 4'd8) wr(A_EOI, 0);
    end

    // register readback (R12)
    rd(6'h02, d); chk("R12 cfg readback", d, 32'h15);
    rd(6'h12, d); chk("R12 handler readback", d, hdl(2));

    // masking (R10)
    wr(6'h04, 32'h07);
    srcIn = 8'h10; settle();
    chk("R10 masked irq", 32'(irq), 0);
    rd(A_VEC, d); chk("R10 masked vector", d, DFLT);
    srcIn = '0; wr(6'h04, 32'h17); settle();

    // edge source (R11, R4)
    wr(6'h05, 32'h18);
    srcIn[5] = 1'b1; repeat (2) @(negedge clk); srcIn[5] = 1'b0;
    settle();
    chk("R11 edge latched irq", 32'(irq), 1);
    rd(A_VEC, d); chk("R3 edge vector", d, hdl(5));
    chk("R4 edge read drops irq", 32'(irq), 0);
    wr(A_EOI, 0); repeat (2) @(negedge clk);
    chk("R4 edge pending cleared", 32'(irq), 0);
    srcIn[3] = 1'b1; settle();
    rd(A_VEC, d); chk("R3 level vector", d, hdl(3));
    wr(A_EOI, 0); @(negedge clk);
    chk("R4 level stays pending", 32'(irq), 1);
    srcIn = '0; settle();

    // nesting (R5, R6, R7)
    srcIn[3] = 1'b1; settle();
    rd(A_VEC, d); chk("R3 outer vector", d, hdl(3));
    srcIn[5] = 1'b1; repeat (2) @(negedge clk); srcIn[5] = 1'b0; settle();
    chk("R6 lower source no irq", 32'(irq), 0);
    srcIn[0] = 1'b1; settle();
    chk("R5 higher source irq", 32'(irq), 1);
    rd(A_VEC, d); chk("R5 nested vector", d, hdl(0));
    chk("R5 irq after nested read", 32'(irq), 0);
    srcIn[0] = 1'b0; settle();
    wr(A_EOI, 0); @(negedge clk);
    chk("R7 popped level holds", 32'(irq), 0);
    srcIn[3] = 1'b0; settle();
    chk("R6 prio0 below level1", 32'(irq), 0);
    wr(A_EOI, 0); @(negedge clk);
    chk("R7 empty stack idles", 32'(irq), 1);
    rd(A_VEC, d); chk("R11 pending edge served", d, hdl(5));
    wr(A_EOI, 0); settle();

    // stack bound (R8)
    srcIn = 8'h18; settle();
    for (int r = 0; r < 10; r++) rd(A_VEC, d);
    chk("R8 repeated vector", d, hdl(4));
    srcIn = 8'h08; settle();
    for (int e = 0; e < 8; e++) wr(A_EOI, 0);
    @(negedge clk);
    chk("R8 still in service after 8 pops", 32'(irq), 0);
    wr(A_EOI, 0); @(negedge clk);
    chk("R8 idle after 9th eoi", 32'(irq), 1);
    rd(A_VEC, d); srcIn = '0; settle(); wr(A_EOI, 0);

    // empty read while busy (R9)
    srcIn[4] = 1'b1; settle();
    rd(A_VEC, d); chk("R3 busy vector", d, hdl(4));
    srcIn = '0; settle();
    rd(A_VEC, d); chk("R9 empty read default", d, DFLT);
    wr(A_EOI, 0);
    srcIn[3] = 1'b1; settle();
    chk("R9 no push on empty read", 32'(irq), 1);
    srcIn = '0; settle();

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule